// File: doc/BRIEF.md
# Byte-Unpack Load Data Formatter

This block sits on a load return path. It takes the raw little-endian bytes that a load returns and widens each byte into its own 16-bit lane of the destination value. Each byte is either zero-extended or sign-extended. A single load therefore yields two or four packed halfword values rather than one extended scalar.

There are two sizes. The pair form takes two bytes and produces a 32-bit result. The quad form takes four bytes and produces a 64-bit result for a register pair. The element-count select and the signed select are captured with the data when the input strobe is high. The formatted result comes out of a register one cycle later, together with a valid flag.

Top module: `unpack_fmt`

## Requirements
- R1: With `sgn_sel`=0, each lane takes its source byte in its low 8 bits, and its upper 8 bits are zero.
- R2: With `sgn_sel`=1, each lane takes its source byte in its low 8 bits, and bit 7 of that byte is copied into all 8 of its upper bits.
- R3: Lane ordering is little-endian. Byte `ld_data[8k+7:8k]` goes to lane k, which is `res[16k+15:16k]`. For example, bytes 0x81, 0x02 give 0x00020081 unsigned and 0x0002FF81 signed.
- R4: With `quad_sel`=1, bytes 0 to 3 produce lanes 0 to 3, and all 64 bits of `res` are used. For example, bytes 0x81, 0x02, 0x83, 0x04 give 0x0004008300020081 unsigned.
- R5: With `quad_sel`=0, only bytes 0 and 1 are used, and `res[63:32]` is zero. Bytes 2 and 3 have no effect on the result.
- R6: `res_vld` is high in the cycle after a cycle in which `ld_vld` is high, and low otherwise. `res` is updated at the same edge.
- R7: `sgn_sel`, `quad_sel` and `ld_data` are sampled only when `ld_vld` is high. While `ld_vld` is low, `res` holds its value.
- R8: After reset, `res_vld` is 0 and `res` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_vld | input | 1 | Load data strobe |
| ld_data | input | 32 | Raw load bytes, with the lowest address in bits 7:0 |
| sgn_sel | input | 1 | 1 selects sign extension, 0 selects zero extension |
| quad_sel | input | 1 | 1 selects four lanes, 0 selects two lanes |
| res | output | 64 | Formatted lanes |
| res_vld | output | 1 | Result valid |

## Verification
Every result is due exactly one clock edge after its strobe, because one register stands between the inputs and the outputs. The bench drives its inputs on the falling edge and compares `res` and `res_vld` on the next falling edge, after the capturing rising edge. To show the held value and the low valid flag, it also samples one further falling edge after dropping the strobe while changing the data and selects. The sweep covers all 256 values of every byte lane in both sign modes and both sizes.

// File: rtl/unpack_fmt.sv
module unpack_fmt #(
  parameter int BYTE_W = 8,
  parameter int LANE_W = 16,
  parameter int MAX_N  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_vld,
  input  logic [MAX_N*BYTE_W-1:0]   ld_data,
  input  logic                      sgn_sel,
  input  logic                      quad_sel,
  output logic [MAX_N*LANE_W-1:0]   res,
  output logic                      res_vld
);
  localparam int EXT_W  = LANE_W - BYTE_W;
  localparam int HALF_N = MAX_N / 2;

  logic [MAX_N*LANE_W-1:0] wide;

  for (genvar k = 0; k < MAX_N; k++) begin : g_lane
    logic [BYTE_W-1:0] b;
    logic              fill;
    logic              keep;
    assign b    = ld_data[k*BYTE_W +: BYTE_W];
    assign fill = sgn_sel & b[BYTE_W-1];
    assign keep = (k < HALF_N) ? 1'b1 : quad_sel;
    assign wide[k*LANE_W +: LANE_W] = keep ? {{EXT_W{fill}}, b} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= ld_vld;
      if (ld_vld) res <= wide;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(ld_vld)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_vld) |-> $stable(res)); // R7
  AST_PAIR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld && !quad_sel |=> res[MAX_N*LANE_W-1:HALF_N*LANE_W] == '0); // R5
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld && !sgn_sel |=> res[LANE_W-1:BYTE_W] == '0); // R1
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld && sgn_sel && ld_data[BYTE_W-1] |=> &res[LANE_W-1:BYTE_W]); // R2
  AST_LANE0_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |=> res[BYTE_W-1:0] == $past(ld_data[BYTE_W-1:0])); // R3
endmodule

// File: tb/tb_unpack_fmt.sv
module tb_unpack_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_vld = 1'b0;
  logic [31:0] ld_data = '0;
  logic        sgn_sel = 1'b0;
  logic        quad_sel = 1'b0;
  logic [63:0] res;
  logic        res_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  unpack_fmt dut (.clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_data(ld_data),
                  .sgn_sel(sgn_sel), .quad_sel(quad_sel), .res(res), .res_vld(res_vld));

  function automatic logic [63:0] model(input logic [31:0] d, input logic s, input logic q);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = d[8*k +: 8];
      if (k < 2 || q)
        r[16*k +: 16] = {8'(s && b[7] ? 8'hFF : 8'h00), b};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] d, input logic s, input logic q, input string tag);
    ld_data = d; sgn_sel = s; quad_sel = q; ld_vld = 1'b1;
    @(negedge clk);
    ld_vld = 1'b0;
    chk({tag, " R6 vld"}, {63'd0, res_vld}, 64'd1);
    chk(tag, res, model(d, s, q));
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R8 res reset", res, 64'd0);
    chk("R8 vld reset", {63'd0, res_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(32'h0000_0281, 1'b0, 1'b0, "R1 R3 pair unsigned");
    chk("R3 literal u", res, 64'h0000_0000_0002_0081);
    issue(32'h0000_0281, 1'b1, 1'b0, "R2 R3 pair signed");
    chk("R3 literal s", res, 64'h0000_0000_0002_FF81);
    issue(32'h0483_0281, 1'b0, 1'b1, "R4 quad unsigned");
    chk("R4 literal", res, 64'h0004_0083_0002_0081);
    issue(32'h0483_0281, 1'b1, 1'b1, "R4 R2 quad signed");
    chk("R4 literal s", res, 64'h0004_FF83_0002_FF81);
    issue(32'hFFFF_0102, 1'b1, 1'b0, "R5 upper bytes ignored");
    chk("R5 upper zero", res, 64'h0000_0000_0001_0002);
    ld_data = 32'hDEAD_BEEF; sgn_sel = 1'b1; quad_sel = 1'b1;
    @(negedge clk);
    chk("R6 vld low", {63'd0, res_vld}, 64'd0);
    chk("R7 hold", res, 64'h0000_0000_0001_0002);
    for (int v = 0; v < 256; v++)
      for (int m = 0; m < 4; m++) begin
        logic [7:0] b;
        b = 8'(v);
        issue({b ^ 8'h5A, ~b, b ^ 8'hA5, b}, m[0], m[1], "R1 R2 R4 R5 sweep");
      end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 re-reset", res, 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule